// File: doc/BRIEF.md
# Packet-Committed Endpoint FIFO Level Tracker

This block is a byte-wide endpoint FIFO that sits between a processor bus and the serial-bus control logic of one endpoint. Each side has push and pop strobes with a data byte. A static direction input decides which side fills the FIFO and which side drains it. Software watches the FIFO through a 16-bit read-only status word. The low bits of that word hold the occupancy.

The occupancy shown to software follows transfer rules rather than raw byte moves. On bulk, control and interrupt endpoints, bytes moved by the control logic count only after their packet ends without error. A packet that ends in error is undone: bytes received in it are dropped, and bytes sent in it are rewound so that they can be sent again. On isochronous endpoints every byte counts as it moves. On a receiving endpoint that is not isochronous, the shown count holds still while an end-of-transfer event waits for acknowledge. Software can then learn how many bytes the last transfer left. In endpoint-0 mode the block models only the host-to-device path.

Top module: `ep_fifo_level`

## Requirements
- R1: `level_word` carries the shown count in bits 8..0, and bits 15..9 are always zero. After reset the whole word is 0, `overflow` is 0 and `eot_pending` is 0. A full FIFO of 256 bytes reads as 16'h0100.
- R2: With `dir_out`=1 the control logic pushes and the CPU pops. With `dir_out`=0 the CPU pushes and the control logic pops. Pushes and pops from the side that does not own that role are ignored and change nothing.
- R3: When `iso_mode`=0, a CPU push or pop changes the shown count in the cycle after the strobe. Control-logic pushes or pops leave it unchanged until a cycle with `pkt_end`=1 and `pkt_err`=0. The count shows the packet's bytes in the cycle after that.
- R4: When `iso_mode`=0, a cycle with `pkt_end`=1 and `pkt_err`=1 leaves the shown count unchanged and discards the control-logic side of the packet. On a receiving endpoint its bytes are never read. On a sending endpoint the next control-logic pop returns the first unsent-and-uncommitted byte again.
- R5: When `iso_mode`=1, every accepted push or pop from either side changes the shown count in the next cycle, and `pkt_end`/`pkt_err` have no effect.
- R6: `eot_set` raises `eot_pending`, and `eot_ack` clears it; if both arrive in the same cycle, set wins. When `dir_out`=1 and `iso_mode`=0, the shown count holds its value while `eot_pending` is 1. In the cycle after the acknowledge, it shows the current committed count.
- R7: With `ep0_mode`=1 the block behaves as `dir_out`=1. CPU pushes and control-logic pops are then ignored.
- R8: A push into a FIFO holding DEPTH bytes is ignored and sets `overflow`, which stays 1 until reset.
- R9: A pop finds no data when the FIFO is empty. On a receiving, non-isochronous endpoint, a pop also finds no data when only uncommitted bytes are present. Such a pop is ignored, and the reader's data output is 0 in the next cycle.
- R10: Bytes leave in the order they were accepted. The popped byte appears on the reader's data output in the cycle after the pop, and the non-reading side's data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_out | input | 1 | 1: control logic fills, CPU drains; 0: reverse |
| iso_mode | input | 1 | Isochronous endpoint, byte-wise counting |
| ep0_mode | input | 1 | Endpoint-0 mode, host-to-device path only |
| cpu_push | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_pop | input | 1 | CPU read strobe |
| cpu_rdata | output | 8 | CPU read byte, valid the cycle after `cpu_pop` |
| usb_push | input | 1 | Control-logic write strobe |
| usb_wdata | input | 8 | Control-logic write byte |
| usb_pop | input | 1 | Control-logic read strobe |
| usb_rdata | output | 8 | Control-logic read byte, valid the cycle after `usb_pop` |
| pkt_end | input | 1 | End-of-packet strobe |
| pkt_err | input | 1 | Qualifies `pkt_end`: packet had an error |
| eot_set | input | 1 | End-of-transfer event |
| eot_ack | input | 1 | Software acknowledge of the end-of-transfer event |
| eot_pending | output | 1 | End-of-transfer event awaiting acknowledge |
| overflow | output | 1 | Sticky: a push met a full FIFO |
| level_word | output | 16 | Status word with shown count in bits 8..0 |

## Verification
The shown count is driven in three ways. Control-logic bytes are followed by a good packet end, which separates committed counting from live counting. Control-logic bytes are followed by a bad packet end in both directions, which shows whether data pointers really roll back or whether only the count is masked. The same byte pattern is replayed in isochronous mode, where the count must move at once and ignore packet ends. Further runs cover the freeze, where pops and new packets arrive during a pending event so that the value after the acknowledge reveals a stale or a live capture. They also cover endpoint-0 gating and fill to exactly 256 bytes plus one, which checks that the extra byte is never stored.

// File: rtl/ep_lvl_pkg.sv
// Shared constants and types for the endpoint FIFO level tracker.
// Assumes the status word layout is fixed: 16 bits, count in the low 9.
package ep_lvl_pkg;
    localparam int WORD_W = 16;
    localparam int LVL_W  = 9;
    localparam int BYTE_W = 8;

    // Static endpoint configuration seen by the datapath
    typedef struct packed {
        logic iso;      // byte-wise counting, no packet commit
        logic out_dir;  // 1: control logic writes, CPU reads
    } ep_mode_t;
endpackage

// File: rtl/ep_fifo_store.sv
// Byte storage of the endpoint FIFO with one write and one read port.
// Read data is registered: it shows the popped byte the cycle after the
// pop, or zero after a pop that found nothing. Storage itself is not reset.
module ep_fifo_store #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [ep_lvl_pkg::BYTE_W-1:0] wr_data,
    input  logic                        rd_en,
    input  logic                        rd_miss,
    input  logic [AW-1:0]               rd_addr,
    output logic [ep_lvl_pkg::BYTE_W-1:0] rd_data
);
    logic [ep_lvl_pkg::BYTE_W-1:0] mem [DEPTH];

    // Store an accepted byte
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Present the popped byte, or zero for a pop that found no data
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (rd_en)   rd_data <= mem[rd_addr];
        else if (rd_miss) rd_data <= '0;
    end

    // R9: a refused pop and an accepted pop never coincide
    a_r9_pop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_miss));
endmodule

// File: rtl/ep_fifo_ptrs.sv
// Pointer, commit-mark and occupancy logic of the endpoint FIFO.
// The control-logic side pointer has a mark taken at each good packet end;
// a bad packet end restores the pointer to that mark. In isochronous mode
// the mark follows the pointer every cycle so committed equals live.
// Assumes DEPTH is a power of two and the mode is static while data moves.
module ep_fifo_ptrs #(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  ep_lvl_pkg::ep_mode_t  mode,
    input  logic                  push_req,
    input  logic                  pop_req,
    input  logic                  pkt_good,
    input  logic                  pkt_bad,
    output logic                  push_ok,
    output logic                  pop_ok,
    output logic [PW-1:0]         wr_ptr,
    output logic [PW-1:0]         rd_ptr,
    output logic [PW-1:0]         cmt_nxt,
    output logic                  overflow
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

    logic [PW-1:0] mark_q;
    logic [PW-1:0] live_cnt, cmt_cnt, fill_cnt, drain_cnt;
    logic [PW-1:0] wr_inc, rd_inc, wr_nxt, rd_nxt, mark_nxt;

    // Occupancy seen live and as committed at the last good packet end
    always_comb begin
        live_cnt = wr_ptr - rd_ptr;
        cmt_cnt  = mode.out_dir ? (mark_q - rd_ptr) : (wr_ptr - mark_q);
        // writer must respect bytes that a rollback could bring back
        fill_cnt  = mode.out_dir ? live_cnt : cmt_cnt;
        // receiving reader may only take committed bytes
        drain_cnt = mode.out_dir ? cmt_cnt : live_cnt;
    end

    // Accept or refuse the requests against room and available data
    always_comb begin
        push_ok = push_req && (fill_cnt < FULL_CNT);
        pop_ok  = pop_req  && (drain_cnt != '0);
        wr_inc  = wr_ptr + {{(PW-1){1'b0}}, push_ok};
        rd_inc  = rd_ptr + {{(PW-1){1'b0}}, pop_ok};
    end

    // Next pointers including rollback of the control-logic side
    always_comb begin
        wr_nxt = (pkt_bad && mode.out_dir)  ? mark_q : wr_inc;
        rd_nxt = (pkt_bad && !mode.out_dir) ? mark_q : rd_inc;
        if (mode.iso || pkt_good) mark_nxt = mode.out_dir ? wr_nxt : rd_nxt;
        else                      mark_nxt = mark_q;
        cmt_nxt = mode.out_dir ? (mark_nxt - rd_nxt) : (wr_nxt - mark_nxt);
    end

    // Advance pointers and mark
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            mark_q <= '0;
        end else begin
            wr_ptr <= wr_nxt;
            rd_ptr <= rd_nxt;
            mark_q <= mark_nxt;
        end
    end

    // Sticky record of a push that met a full FIFO
    always_ff @(posedge clk) begin
        if (!rst_n)                      overflow <= 1'b0;
        else if (push_req && !push_ok)   overflow <= 1'b1;
    end

    // R8: once set, overflow stays set
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    // R8: a push into a full FIFO moves no write pointer
    a_r8_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && live_cnt == FULL_CNT && !pkt_bad) |=> $stable(wr_ptr));
    // R4: a bad receive packet returns the write pointer to the mark
    a_r4_rx_rollback: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_bad && mode.out_dir) |=> (wr_ptr == $past(mark_q)));
    // R4: a bad send packet returns the read pointer to the mark
    a_r4_tx_rollback: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_bad && !mode.out_dir) |=> (rd_ptr == $past(mark_q)));
    // R9: occupancy never exceeds DEPTH in either view
    a_r9_count_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt <= FULL_CNT) && (cmt_cnt <= FULL_CNT));
endmodule

// File: rtl/ep_level_view.sv
// Shown-count register and end-of-transfer flag.
// The shown count loads the next committed count every cycle except while
// an end-of-transfer event is pending on a receiving, non-isochronous
// endpoint and no acknowledge arrives. Set wins over acknowledge.
module ep_level_view #(
    parameter int PW = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ep_lvl_pkg::ep_mode_t mode,
    input  logic [PW-1:0]        cmt_nxt,
    input  logic                 eot_set,
    input  logic                 eot_ack,
    output logic                 eot_pending,
    output logic [PW-1:0]        shown_cnt
);
    logic hold;

    // Freeze condition for the coming edge
    always_comb hold = eot_pending && !eot_ack && mode.out_dir && !mode.iso;

    // End-of-transfer pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) eot_pending <= 1'b0;
        else        eot_pending <= eot_set || (eot_pending && !eot_ack);
    end

    // Shown count: follow committed count unless frozen
    always_ff @(posedge clk) begin
        if (!rst_n)     shown_cnt <= '0;
        else if (!hold) shown_cnt <= cmt_nxt;
    end

    // R6: acknowledge without a new event drops the pending flag
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_ack && !eot_set) |=> !eot_pending);
    // R6: an event always leaves the flag raised
    a_r6_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        eot_set |=> eot_pending);
endmodule

// File: rtl/ep_fifo_level.sv
// Endpoint FIFO with a packet-committed occupancy status word.
// Routes CPU and control-logic strobes to writer/reader roles from the
// direction and endpoint-0 inputs, gates packet ends off in isochronous
// mode, and packs the shown count into the low bits of the status word.
// Assumes dir_out, iso_mode and ep0_mode change only while the FIFO is idle.
module ep_fifo_level #(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dir_out,
    input  logic        iso_mode,
    input  logic        ep0_mode,
    input  logic        cpu_push,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_pop,
    output logic [7:0]  cpu_rdata,
    input  logic        usb_push,
    input  logic [7:0]  usb_wdata,
    input  logic        usb_pop,
    output logic [7:0]  usb_rdata,
    input  logic        pkt_end,
    input  logic        pkt_err,
    input  logic        eot_set,
    input  logic        eot_ack,
    output logic        eot_pending,
    output logic        overflow,
    output logic [15:0] level_word
);
    import ep_lvl_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    ep_mode_t          mode;
    logic              push_req, pop_req, push_ok, pop_ok;
    logic              pkt_good, pkt_bad;
    logic [BYTE_W-1:0] wdata, rdata;
    logic [PW-1:0]     wr_ptr, rd_ptr, cmt_nxt, shown_cnt;

    // Role routing and packet qualification
    always_comb begin
        mode.out_dir = dir_out || ep0_mode;
        mode.iso     = iso_mode;
        push_req     = mode.out_dir ? usb_push  : cpu_push;
        pop_req      = mode.out_dir ? cpu_pop   : usb_pop;
        wdata        = mode.out_dir ? usb_wdata : cpu_wdata;
        pkt_good     = pkt_end && !pkt_err && !iso_mode;
        pkt_bad      = pkt_end &&  pkt_err && !iso_mode;
    end

    ep_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .push_req (push_req),
        .pop_req  (pop_req),
        .pkt_good (pkt_good),
        .pkt_bad  (pkt_bad),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .cmt_nxt  (cmt_nxt),
        .overflow (overflow)
    );

    ep_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_ok),
        .wr_addr (wr_ptr[AW-1:0]),
        .wr_data (wdata),
        .rd_en   (pop_ok),
        .rd_miss (pop_req && !pop_ok),
        .rd_addr (rd_ptr[AW-1:0]),
        .rd_data (rdata)
    );

    ep_level_view #(.PW(PW)) u_view (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .cmt_nxt     (cmt_nxt),
        .eot_set     (eot_set),
        .eot_ack     (eot_ack),
        .eot_pending (eot_pending),
        .shown_cnt   (shown_cnt)
    );

    // Output packing: reader side gets data, status word zero-extended
    always_comb begin
        cpu_rdata  = mode.out_dir ? rdata : '0;
        usb_rdata  = mode.out_dir ? '0 : rdata;
        level_word = WORD_W'(shown_cnt);
    end

    // R1: reserved bits of the status word stay clear
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        level_word[15:LVL_W] == '0);
    // R3: without CPU traffic, packet end or acknowledge, the count holds
    a_r3_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!iso_mode && !cpu_push && !cpu_pop && !pkt_end && !eot_ack)
        |=> $stable(level_word));
    // R6: frozen count on a receiving non-isochronous endpoint
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_pending && !eot_ack && (dir_out || ep0_mode) && !iso_mode)
        |=> $stable(level_word));
    // R5: in isochronous mode a packet end alone moves nothing
    a_r5_iso_ignores_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_mode && pkt_end && !cpu_push && !cpu_pop && !usb_push && !usb_pop)
        |=> $stable(level_word));
endmodule

// File: tb/ep_fifo_level_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module ep_fifo_level_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dir_out, iso_mode, ep0_mode;
    logic        cpu_push, cpu_pop, usb_push, usb_pop;
    logic [7:0]  cpu_wdata, usb_wdata, cpu_rdata, usb_rdata;
    logic        pkt_end, pkt_err, eot_set, eot_ack;
    logic        eot_pending, overflow;
    logic [15:0] level_word;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    ep_fifo_level u_dut (
        .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .iso_mode(iso_mode),
        .ep0_mode(ep0_mode), .cpu_push(cpu_push), .cpu_wdata(cpu_wdata),
        .cpu_pop(cpu_pop), .cpu_rdata(cpu_rdata), .usb_push(usb_push),
        .usb_wdata(usb_wdata), .usb_pop(usb_pop), .usb_rdata(usb_rdata),
        .pkt_end(pkt_end), .pkt_err(pkt_err), .eot_set(eot_set),
        .eot_ack(eot_ack), .eot_pending(eot_pending), .overflow(overflow),
        .level_word(level_word)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic lvl(input string req, input int exp);
        check(req, int'(level_word), exp);
    endtask

    task automatic do_reset(input logic d, input logic iso, input logic e0);
        dir_out = d; iso_mode = iso; ep0_mode = e0;
        cpu_push = 0; cpu_pop = 0; usb_push = 0; usb_pop = 0;
        cpu_wdata = 0; usb_wdata = 0;
        pkt_end = 0; pkt_err = 0; eot_set = 0; eot_ack = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic usb_wr(input logic [7:0] b);
        usb_push = 1; usb_wdata = b; @(negedge clk); usb_push = 0;
    endtask
    task automatic cpu_wr(input logic [7:0] b);
        cpu_push = 1; cpu_wdata = b; @(negedge clk); cpu_push = 0;
    endtask
    task automatic cpu_rd(output logic [7:0] b);
        cpu_pop = 1; @(negedge clk); cpu_pop = 0; b = cpu_rdata;
    endtask
    task automatic usb_rd(output logic [7:0] b);
        usb_pop = 1; @(negedge clk); usb_pop = 0; b = usb_rdata;
    endtask
    task automatic pkt(input logic err, input logic eot);
        pkt_end = 1; pkt_err = err; eot_set = eot;
        @(negedge clk);
        pkt_end = 0; pkt_err = 0; eot_set = 0;
    endtask
    task automatic ack();
        eot_ack = 1; @(negedge clk); eot_ack = 0;
    endtask

    task automatic t_reset();
        do_reset(1, 0, 0);
        rst_n = 0;
        lvl("R1 reset word", 0);
        check("R1 reset overflow", int'(overflow), 0);
        check("R1 reset eot_pending", int'(eot_pending), 0);
        rst_n = 1;
    endtask

    task automatic t_out_commit();
        logic [7:0] b;
        do_reset(1, 0, 0);
        usb_wr(8'hA1); usb_wr(8'hA2); usb_wr(8'hA3);
        lvl("R3 uncommitted rx bytes hidden", 0);
        cpu_rd(b);
        check("R9 pop of uncommitted data returns 0", int'(b), 0);
        pkt(0, 0);
        lvl("R3 good packet end commits", 3);
        cpu_rd(b);
        check("R10 first byte out", int'(b), 'hA1);
        check("R10 idle side reads 0", int'(usb_rdata), 0);
        lvl("R3 cpu pop counts at once", 2);
        cpu_rd(b);
        check("R10 second byte out", int'(b), 'hA2);
        lvl("R3 count after second pop", 1);
    endtask

    task automatic t_out_error();
        logic [7:0] b;
        do_reset(1, 0, 0);
        usb_wr(8'h11); usb_wr(8'h22); pkt(0, 0);
        usb_wr(8'h33); usb_wr(8'h44); pkt(1, 0);
        lvl("R4 bad rx packet leaves count", 2);
        cpu_rd(b); check("R4 committed byte 0", int'(b), 'h11);
        cpu_rd(b); check("R4 committed byte 1", int'(b), 'h22);
        cpu_rd(b);
        check("R9 pop on empty returns 0", int'(b), 0);
        lvl("R9 count after empty pop", 0);
        usb_wr(8'h55); pkt(0, 0);
        lvl("R4 new packet after rollback", 1);
        cpu_rd(b); check("R4 discarded bytes never read", int'(b), 'h55);
    endtask

    task automatic t_in_rewind();
        logic [7:0] b;
        do_reset(0, 0, 0);
        for (int i = 0; i < 4; i++) cpu_wr(8'(8'h60 + i));
        lvl("R3 cpu pushes count at once", 4);
        usb_rd(b); check("R10 tx byte 0", int'(b), 'h60);
        usb_rd(b);
        lvl("R3 uncommitted tx pops hidden", 4);
        check("R10 cpu side reads 0 when idle", int'(cpu_rdata), 0);
        pkt(1, 0);
        lvl("R4 bad tx packet leaves count", 4);
        usb_rd(b); check("R4 tx rewound to first byte", int'(b), 'h60);
        for (int i = 1; i < 4; i++) begin
            usb_rd(b);
            check("R10 tx order after rewind", int'(b), 'h60 + i);
        end
        pkt(0, 0);
        lvl("R3 good tx packet commits pops", 0);
        usb_wr(8'h99); pkt(0, 0);
        lvl("R2 wrong-side push ignored", 0);
    endtask

    task automatic t_iso();
        logic [7:0] b;
        do_reset(1, 1, 0);
        usb_wr(8'h07);
        lvl("R5 iso push counts at once", 1);
        usb_wr(8'h08);
        lvl("R5 iso second push", 2);
        pkt(1, 0);
        lvl("R5 iso ignores bad packet end", 2);
        cpu_rd(b);
        check("R5 iso data kept", int'(b), 'h07);
        lvl("R5 iso pop counts at once", 1);
    endtask

    task automatic t_freeze();
        logic [7:0] b;
        do_reset(1, 0, 0);
        usb_wr(8'hC0); usb_wr(8'hC1); usb_wr(8'hC2);
        pkt(0, 1);
        lvl("R6 count at end of transfer", 3);
        check("R6 pending raised", int'(eot_pending), 1);
        cpu_rd(b); cpu_rd(b);
        lvl("R6 frozen across pops", 3);
        usb_wr(8'hD0); usb_wr(8'hD1); usb_wr(8'hD2); pkt(0, 0);
        lvl("R6 frozen across new packet", 3);
        ack();
        check("R6 pending cleared", int'(eot_pending), 0);
        lvl("R6 count after acknowledge", 4);
    endtask

    task automatic t_ep0();
        logic [7:0] b;
        do_reset(0, 0, 1);
        cpu_wr(8'h42);
        lvl("R7 ep0 cpu push ignored", 0);
        usb_wr(8'h5A); pkt(0, 0);
        lvl("R7 ep0 rx path counts", 1);
        usb_rd(b);
        check("R7 ep0 usb pop reads 0", int'(b), 0);
        lvl("R7 ep0 usb pop ignored", 1);
        cpu_rd(b);
        check("R7 ep0 cpu reads rx byte", int'(b), 'h5A);
    endtask

    task automatic t_full();
        logic [7:0] b;
        do_reset(1, 1, 0);
        for (int i = 0; i < 256; i++) usb_wr(8'(i + 1));
        lvl("R1 full word 16'h0100", 'h100);
        check("R8 no overflow at exactly full", int'(overflow), 0);
        usb_wr(8'hEE);
        lvl("R8 push on full ignored", 256);
        check("R8 overflow set", int'(overflow), 1);
        cpu_rd(b);
        check("R8 extra byte not stored", int'(b), 1);
        check("R8 overflow sticky", int'(overflow), 1);
        lvl("R8 count after pop", 255);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual %0d expected %0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_out_commit();
        t_out_error();
        t_in_rewind();
        t_iso();
        t_freeze();
        t_ep0();
        t_full();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule